// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block works out the six arithmetic status flags for one add or subtract result. The caller supplies both operands, the result the adder produced, a select that says whether the operation was a subtraction, and a two-bit operand-size code. The block returns carry (borrow on subtraction), low-byte parity, nibble carry, zero, sign and signed overflow. It has no clock and no state. An ALU wrapper places it next to the adder and reads the flags in the same cycle.

The flags also come out merged into a 32-bit flags word, each at a fixed bit position, together with a mask that marks exactly those positions. A flags register can then update with `(old & ~mask) | word` and leave its control and system bits alone. Operand and result bits above the selected size are ignored, except that parity and nibble carry always use the low byte.

The design has no sequential logic. In place of a state list it has one named selection per size code: BYTE (code 0, 8 bits), HALF (code 1, 16 bits), WORD (code 2, 32 bits) and WIDE (code 3, which takes the WORD path).

Top module: `sflag_gen`

## Requirements
- R1: With size code 0 the width is 8 bits, with code 1 it is 16 and with code 2 it is 32. Operand and result bits above that width do not affect carry, zero, sign or overflow.
- R2: On addition (`sub_sel`=0) `cf` is the carry out of the top bit of the width, meaning the unsigned sum of the width-limited operands is at least 2^width.
- R3: On subtraction (`sub_sel`=1) `cf` is the borrow, meaning the width-limited `op_a` is unsigned-less-than the width-limited `op_b`.
- R4: `pf` is 1 when `res[7:0]` holds an even number of 1 bits, whatever the size.
- R5: `af` equals bit 4 of `op_a ^ op_b ^ res`, whatever the size.
- R6: `zf` is 1 exactly when the width-limited result is zero.
- R7: `sf` equals the top bit of the width-limited result.
- R8: `of` on addition is 1 when both operand sign bits match and the result sign differs from them. On subtraction it is 1 when the operand sign bits differ and the result sign differs from the `op_a` sign.
- R9: In `flag_word`, `cf` sits at bit 0, `pf` at bit 2, `af` at bit 4, `zf` at bit 6, `sf` at bit 7 and `of` at bit 11. Every other bit is 0.
- R10: `flag_mask` is 0x0000_08D5, with only bits 0, 2, 4, 6, 7 and 11 set.
- R11: Size code 3 gives the same outputs as size code 2 for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | DATA_W | First operand (minuend on subtraction) |
| op_b | input | DATA_W | Second operand (subtrahend on subtraction) |
| res | input | DATA_W | Result produced by the adder |
| sub_sel | input | 1 | 1 = subtraction, 0 = addition |
| op_size | input | 2 | Width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| cf | output | 1 | Carry / borrow |
| pf | output | 1 | Even parity of result low byte |
| af | output | 1 | Carry or borrow out of bit 3 |
| zf | output | 1 | Width-limited result is zero |
| sf | output | 1 | Top bit of width-limited result |
| of | output | 1 | Signed overflow |
| flag_word | output | 32 | Flags merged at their fixed positions |
| flag_mask | output | 32 | Positions occupied by the flags |

## Verification
The bench builds the block with the default DATA_W of 32, so all three lane widths exist and the upper operand bits above 8 and 16 bits can be loaded with unrelated data. That reaches the R1 masking cases and the case where 32-bit carry-out needs a 33rd bit in the reference. Directed vectors hit the sign boundaries 0x7F/0x80, 0x7FFF/0x8000 and 0x7FFFFFFF/0x80000000, wraparound to zero, and equal-operand subtraction. A random stream then covers every size code, including code 3, against the behavioural reference.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    // Operand-size codes as seen on the op_size port
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_WIDE = 2'b11;

    // Width of the merged flags word
    localparam int FLAG_W = 32;

    // Bit positions inside the flags word (a flags register decodes these)
    localparam int CF_POS = 0;
    localparam int PF_POS = 2;
    localparam int AF_POS = 4;
    localparam int ZF_POS = 6;
    localparam int SF_POS = 7;
    localparam int OF_POS = 11;

    // Width covered by parity and the nibble boundary used for aux carry
    localparam int PAR_W  = 8;
    localparam int NIB_HI = 4;

    // Number of selectable lane widths: 8, 16, 32
    localparam int NUM_LANES = 3;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    typedef struct packed {
        logic a_msb;
        logic b_msb;
        logic r_msb;
        logic r_zero;
    } lane_t;

endpackage

// File: rtl/sflag_lane.sv
// Width-limited view of operands and result for one operand size.
module sflag_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_slice,
    input  logic [LANE_W-1:0] b_slice,
    input  logic [LANE_W-1:0] r_slice,
    output sflag_pkg::lane_t  lane
);
    localparam int TOP = LANE_W - 1;

    logic [TOP-1:0] a_low_unused;
    logic [TOP-1:0] b_low_unused;

    always_comb begin
        lane.a_msb   = a_slice[TOP];
        lane.b_msb   = b_slice[TOP];
        lane.r_msb   = r_slice[TOP];
        lane.r_zero  = (r_slice == '0);
        // low operand bits only matter through res; keep them visibly sunk
        a_low_unused = a_slice[TOP-1:0];
        b_low_unused = b_slice[TOP-1:0];
    end

    logic sink;
    assign sink = ^{a_low_unused, b_low_unused};

endmodule

// File: rtl/sflag_core.sv
// Carry/borrow and signed overflow from the sign bits of the selected lane.
module sflag_core (
    input  logic sub_sel,
    input  logic a_msb,
    input  logic b_msb,
    input  logic r_msb,
    output logic carry,
    output logic ovf
);
    logic add_carry;
    logic sub_borrow;
    logic add_ovf;
    logic sub_ovf;

    always_comb begin
        // carry out of top bit, reconstructed from sign bits of a, b, sum
        add_carry  = (a_msb & b_msb) | ((a_msb | b_msb) & ~r_msb);
        // borrow into top bit of a - b
        sub_borrow = (~a_msb & b_msb) | ((~a_msb | b_msb) & r_msb);
        add_ovf    = (a_msb == b_msb) & (r_msb != a_msb);
        sub_ovf    = (a_msb != b_msb) & (r_msb != a_msb);

        unique case (sub_sel)
            1'b1:    begin carry = sub_borrow; ovf = sub_ovf; end
            default: begin carry = add_carry;  ovf = add_ovf; end
        endcase
    end

endmodule

// File: rtl/sflag_lowbyte.sv
// Flags that ignore operand size: low-byte parity and nibble carry.
module sflag_lowbyte #(
    parameter int PW = sflag_pkg::PAR_W
) (
    input  logic [PW-1:0] r_low,
    input  logic          a_nib,
    input  logic          b_nib,
    output logic          parity_even,
    output logic          nib_carry
);
    logic [PW:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < PW; i++) begin : g_par
        assign chain[i+1] = chain[i] ^ r_low[i];
    end

    assign parity_even = ~chain[PW];
    assign nib_carry   = a_nib ^ b_nib ^ r_low[sflag_pkg::NIB_HI];

endmodule

// File: rtl/sflag_pack.sv
// Places flags at their fixed positions and produces the matching mask.
module sflag_pack #(
    parameter int FW = sflag_pkg::FLAG_W
) (
    input  sflag_pkg::flags_t flags,
    output logic [FW-1:0]     word,
    output logic [FW-1:0]     mask
);
    import sflag_pkg::*;

    always_comb begin
        word = '0;
        mask = '0;
        word[CF_POS] = flags.cf;  mask[CF_POS] = 1'b1;
        word[PF_POS] = flags.pf;  mask[PF_POS] = 1'b1;
        word[AF_POS] = flags.af;  mask[AF_POS] = 1'b1;
        word[ZF_POS] = flags.zf;  mask[ZF_POS] = 1'b1;
        word[SF_POS] = flags.sf;  mask[SF_POS] = 1'b1;
        word[OF_POS] = flags.of;  mask[OF_POS] = 1'b1;
    end

endmodule

// File: rtl/sflag_gen.sv
module sflag_gen #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]            op_a,
    input  logic [DATA_W-1:0]            op_b,
    input  logic [DATA_W-1:0]            res,
    input  logic                         sub_sel,
    input  logic [1:0]                   op_size,
    output logic                         cf,
    output logic                         pf,
    output logic                         af,
    output logic                         zf,
    output logic                         sf,
    output logic                         of,
    output logic [sflag_pkg::FLAG_W-1:0] flag_word,
    output logic [sflag_pkg::FLAG_W-1:0] flag_mask
);
    import sflag_pkg::*;

    sflag_pkg::lane_t lanes [NUM_LANES];
    sflag_pkg::lane_t sel;

    // One lane per operand size; width is 8 << index, capped at DATA_W
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int LW = ((8 << i) < DATA_W) ? (8 << i) : DATA_W;
        sflag_lane #(.LANE_W(LW)) u_lane (
            .a_slice (op_a[LW-1:0]),
            .b_slice (op_b[LW-1:0]),
            .r_slice (res[LW-1:0]),
            .lane    (lanes[i])
        );
    end

    // Size selection: BYTE, HALF, WORD; WIDE shares the WORD path
    always_comb begin
        unique case (op_size)
            SZ_BYTE: sel = lanes[0];
            SZ_HALF: sel = lanes[1];
            SZ_WORD: sel = lanes[2];
            SZ_WIDE: sel = lanes[2];
            default: sel = lanes[2];
        endcase
    end

    logic carry_w;
    logic ovf_w;

    sflag_core u_core (
        .sub_sel (sub_sel),
        .a_msb   (sel.a_msb),
        .b_msb   (sel.b_msb),
        .r_msb   (sel.r_msb),
        .carry   (carry_w),
        .ovf     (ovf_w)
    );

    logic par_w;
    logic nib_w;

    sflag_lowbyte #(.PW(PAR_W)) u_low (
        .r_low       (res[PAR_W-1:0]),
        .a_nib       (op_a[NIB_HI]),
        .b_nib       (op_b[NIB_HI]),
        .parity_even (par_w),
        .nib_carry   (nib_w)
    );

    flags_t flags;

    always_comb begin
        flags.cf = carry_w;
        flags.pf = par_w;
        flags.af = nib_w;
        flags.zf = sel.r_zero;
        flags.sf = sel.r_msb;
        flags.of = ovf_w;
    end

    assign cf = flags.cf;
    assign pf = flags.pf;
    assign af = flags.af;
    assign zf = flags.zf;
    assign sf = flags.sf;
    assign of = flags.of;

    sflag_pack #(.FW(FLAG_W)) u_pack (
        .flags (flags),
        .word  (flag_word),
        .mask  (flag_mask)
    );

endmodule

// File: rtl/sflag_gen_chk.sv
module sflag_gen_chk #(
    parameter int DATA_W = 32
) (
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [DATA_W-1:0] res,
    input logic              sub_sel,
    input logic [1:0]        op_size,
    input logic              cf,
    input logic              pf,
    input logic              af,
    input logic              zf,
    input logic              sf,
    input logic              of,
    input logic [31:0]       flag_word,
    input logic [31:0]       flag_mask
);
    logic sa;
    logic sb;
    logic sr;
    logic known;

    always_comb begin
        known = !$isunknown({op_a, op_b, res, sub_sel, op_size});
        case (op_size)
            2'b00:   begin sa = op_a[7];  sb = op_b[7];  sr = res[7];  end
            2'b01:   begin sa = op_a[15]; sb = op_b[15]; sr = res[15]; end
            default: begin sa = op_a[31]; sb = op_b[31]; sr = res[31]; end
        endcase
    end

    always_comb begin
        if (known) begin
            // R9
            word_pos_chk: assert (flag_word == {20'd0, of, 3'd0, sf, zf, 1'b0, af, 1'b0, pf, 1'b0, cf});
            // R10
            word_in_mask_chk: assert ((flag_word & ~flag_mask) == 32'd0);
            // R7
            sign_bit_chk: assert (sf == sr);
            // R6
            zero_no_sign_chk: assert (!(zf && sf));
            // R8
            no_overflow_chk: assert (!(of && !sub_sel && (sa != sb)));
            // R8
            sub_overflow_chk: assert (!(of && sub_sel && (sa == sb)));
            // R4
            parity_chk: assert (pf == ~^res[7:0]);
            // R5
            nibble_chk: assert (af == (op_a[4] ^ op_b[4] ^ res[4]));
        end
    end

    logic sink;
    assign sink = ^{op_a, op_b, res, flag_mask};

endmodule

bind sflag_gen sflag_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .res       (res),
    .sub_sel   (sub_sel),
    .op_size   (op_size),
    .cf        (cf),
    .pf        (pf),
    .af        (af),
    .zf        (zf),
    .sf        (sf),
    .of        (of),
    .flag_word (flag_word),
    .flag_mask (flag_mask)
);

// File: tb/sim_sflag_gen.sv
module sim_sflag_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int N_RANDOM = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [DW-1:0] op_a, op_b, res;
    logic          sub_sel;
    logic [1:0]    op_size;
    logic cf, pf, af, zf, sf, of;
    logic [31:0] flag_word, flag_mask;

    sflag_gen #(.DATA_W(DW)) u0 (
        .op_a(op_a), .op_b(op_b), .res(res), .sub_sel(sub_sel), .op_size(op_size),
        .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of),
        .flag_word(flag_word), .flag_mask(flag_mask)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h (a=%08h b=%08h r=%08h sub=%0b sz=%0d)",
                     tag, act, exp, op_a, op_b, res, sub_sel, op_size);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Behavioural reference, computed from the requirements
    task automatic compare_all();
        int n;
        longint unsigned m, a, b, r;
        bit e_cf, e_pf, e_af, e_zf, e_sf, e_of, sa, sb, sr;
        int ones;
        logic [31:0] e_word;
        n = (op_size == 2'd0) ? 8 : (op_size == 2'd1) ? 16 : 32;   // R1, R11
        m = (64'd1 << n) - 1;
        a = longint'(op_a) & m;
        b = longint'(op_b) & m;
        r = longint'(res) & m;
        if (sub_sel) e_cf = (a < b);                      // R3
        else         e_cf = (((a + b) >> n) & 1) != 0;    // R2
        ones = 0;
        for (int i = 0; i < 8; i++) ones += res[i];
        e_pf = (ones % 2) == 0;                           // R4
        e_af = ((op_a ^ op_b ^ res) >> 4) & 1;            // R5
        e_zf = (r == 0);                                  // R6
        sa = (a >> (n-1)) & 1;
        sb = (b >> (n-1)) & 1;
        sr = (r >> (n-1)) & 1;
        e_sf = sr;                                        // R7
        e_of = sub_sel ? (sa != sb && sr != sa) : (sa == sb && sr != sa); // R8
        e_word = 32'd0;
        if (e_cf) e_word = e_word + 32'd1;
        if (e_pf) e_word = e_word + 32'd4;
        if (e_af) e_word = e_word + 32'd16;
        if (e_zf) e_word = e_word + 32'd64;
        if (e_sf) e_word = e_word + 32'd128;
        if (e_of) e_word = e_word + 32'd2048;
        chk(sub_sel ? "R3 borrow" : "R2 carry", {31'd0, cf}, {31'd0, e_cf});
        chk("R4 parity", {31'd0, pf}, {31'd0, e_pf});
        chk("R5 aux", {31'd0, af}, {31'd0, e_af});
        chk("R6 zero", {31'd0, zf}, {31'd0, e_zf});
        chk("R7 sign", {31'd0, sf}, {31'd0, e_sf});
        chk("R8 overflow", {31'd0, of}, {31'd0, e_of});
        chk("R9 word", flag_word, e_word);
        chk("R10 mask", flag_mask, 32'h0000_08D5);
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s, input logic [1:0] z);
        @(negedge clk);
        op_a = a; op_b = b; sub_sel = s; op_size = z;
        res = s ? (a - b) : (a + b);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] w0;
        op_a = '0; op_b = '0; res = '0; sub_sel = 1'b0; op_size = 2'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        compare_all();  // idle inputs: zero result, even parity

        // Directed sign and wrap boundaries
        apply(32'h0000_007F, 32'h0000_0001, 1'b0, 2'd0);
        apply(32'h0000_00FF, 32'h0000_0001, 1'b0, 2'd0);
        apply(32'h0000_0000, 32'h0000_0001, 1'b1, 2'd0);
        apply(32'h0000_0080, 32'h0000_0001, 1'b1, 2'd0);
        apply(32'h0000_8000, 32'h0000_0001, 1'b1, 2'd1);
        apply(32'h0000_7FFF, 32'h0000_7FFF, 1'b0, 2'd1);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'd2);
        apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 2'd2);
        apply(32'h8000_0000, 32'h8000_0000, 1'b1, 2'd2);
        apply(32'h8000_0000, 32'h0000_0001, 1'b1, 2'd3);
        apply(32'h1234_5678, 32'h1234_5678, 1'b1, 2'd2);

        // R1: upper bits above byte width must not change flags
        apply(32'h0000_0042, 32'h0000_0013, 1'b0, 2'd0);
        w0 = flag_word;
        apply(32'hABCD_E042, 32'h5A5A_A513, 1'b0, 2'd0);
        chk("R1 upper bits ignored (8-bit)", flag_word & 32'h0000_08C1, w0 & 32'h0000_08C1);

        // R11: code 3 matches code 2
        apply(32'h9000_0001, 32'h7000_0002, 1'b1, 2'd2);
        w0 = flag_word;
        apply(32'h9000_0001, 32'h7000_0002, 1'b1, 2'd3);
        chk("R11 size code 3 equals 2", flag_word, w0);

        for (int k = 0; k < N_RANDOM; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (k % 7 == 0) rb = ra;
            apply(ra, rb, 1'($urandom), 2'($urandom));
        end

        done = 1;
        summary();
    end

endmodule